// File: doc/BRIEF.md
# I2C Slave Event Detector and Status Register

This block is the front end of an I2C target device. It samples the raw SCL and SDA lines through two-stage synchronizers and watches for START, repeated START and STOP conditions at the system clock rate. After each START it captures the first byte. It then either matches the 7-bit address against four programmable identifiers or treats the byte as a general call, in which case it decodes the byte that follows.

The results go into a 15-bit status word. Each bit has its own set event and its own clear trigger. The set events are bus conditions, or single-cycle strobes from the neighbouring data path: FIFO, transmit and receive logic, which live outside this block. The clear triggers are a STOP, a status read, a status write, a TX write, an RX read, a config write with bit 8 set, or the TX occupancy count reaching its depth.

A small register port reads and writes four registers, selected by `reg_sel_i`: 0 status, 1 RX, 2 TX, 3 config. Status reads return the live word. A general-call reset returns the whole block to its default state. There is no streaming data path here, so every pin is a plain level or a single-cycle strobe.

Top module: `i2c_slv_status`

## Requirements
- R1: After reset the status word is 0x0001: only bit 0 (TX not full) is set. A read with `reg_sel_i`=0 returns the status word in bits 14:0, and bits 31:15 always read zero. Reads of RX (1), TX (2) and config (3) return zero.
- R2: A START, then an address byte whose upper 7 bits equal an identifier, with no START since the last STOP, sets bit 14 (start matched) and bit 6 (busy). Bit 14 is cleared only by a STOP or by a general-call reset, and bit 6 is cleared by the next STOP.
- R3: A START seen while a transfer is already open (repeated START), followed by a matching address, sets bit 13. A STOP, a status read or a general-call reset clears it.
- R4: Bits 12:11 hold the index (0 to 3) of the identifier that matched. When several identifiers are equal, the lowest index wins. An address that matches nothing leaves the status word unchanged.
- R5: A STOP that follows a matched address sets bit 10, and a status read clears it. A STOP with no matched address since the last START leaves bit 10 alone.
- R6: An address byte of exactly 0x00 is a general call and sets bit 7. The next byte sets bits 9:8 as follows: 0x06 gives 01 (reset and program), 0x04 gives 10 (program only), a byte with bit 0 set and bits 7:1 equal to the alternative ID gives 11, and any other byte gives 00.
- R7: A general-call reset (second byte 0x06) returns every status bit and the TX count to their reset values, except bits 9:7, which record the call itself (status becomes 0x0181).
- R8: A config write with bit 8 of the write data set clears bit 7. A config write with bit 8 clear leaves bit 7 unchanged.
- R9: The no-data strobe sets bit 5 and the RX-overflow strobe sets bit 4. A status read clears both.
- R10: The byte-received strobe sets bit 3. A read of the RX register or a flush strobe clears it.
- R11: The transmit-done strobe sets bit 2, and a write to TX clears it. The underflow strobe sets bit 1, and a write to the status register clears it.
- R12: Bit 0 is 1 while the TX count is below TX_DEPTH (2). Each TX write adds one to the count and each pop strobe removes one, saturating at TX_DEPTH and at 0. Two TX writes therefore clear bit 0.
- R13: When a set event and a clear trigger for the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line, not synchronized |
| sda_i | input | 1 | Raw SDA line, not synchronized |
| id_tbl_i | input | 28 | Four 7-bit identifiers; identifier n sits in bits 7n+6:7n |
| alt_id_i | input | 7 | Alternative ID compared against a hardware general call |
| rx_byte_i | input | 1 | Strobe: a data byte was received |
| rx_ovf_i | input | 1 | Strobe: the receive FIFO overflowed |
| rx_flush_i | input | 1 | Strobe: the receive FIFO was flushed |
| rd_empty_i | input | 1 | Strobe: the master asked for data and none was available |
| tx_done_i | input | 1 | Strobe: a transmission ended |
| tx_unf_i | input | 1 | Strobe: the transmit FIFO underflowed |
| tx_pop_i | input | 1 | Strobe: one TX entry was consumed |
| reg_sel_i | input | 2 | Register select: 0 status, 1 RX, 2 TX, 3 config |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data; only bit 8 of a config write is used |
| reg_rdata_o | output | 32 | Register read data, combinational from the current state |
| stat_o | output | 15 | Live status word, observable without side effects |

## Verification
The bound checker covers the bits whose behaviour is a local rule on every cycle. It checks that the upper read bits are zero, that a clear trigger without a matching set event leaves its bit low, that a set event wins over a clear, that busy only rises together with an address-match flag, that the start flag only falls on a STOP or a general-call reset, and that TX-not-full only falls after a TX write. The address comparison, the lowest-index priority, the repeated-START distinction, the general-call decode and the full effect of the reset call all depend on a complete serial byte on the lines. Only the bench scenarios can show these, by driving real START, byte and STOP sequences against its own model of the status word.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int ADDR_W = 7;                 // I2C 7-bit addressing
  localparam int N_ID   = 4;                 // fixed by the 2-bit ID field
  localparam int IDX_W  = $clog2(N_ID);
  localparam int STAT_W = 15;
  localparam int BUS_W  = 32;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_RX   = 2'd1,
    SEL_TX   = 2'd2,
    SEL_CFG  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_GC2,
    PH_XFER
  } phase_e;

  typedef enum logic [1:0] {
    GC_NONE     = 2'b00,
    GC_RST_PROG = 2'b01,
    GC_PROG     = 2'b10,
    GC_ALT      = 2'b11
  } gc_kind_e;

  localparam logic [7:0] GC_CODE_RST  = 8'h06;
  localparam logic [7:0] GC_CODE_PROG = 8'h04;
  localparam int CFG_GC_CLR_BIT = 8;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2     // must be at least 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  // lines idle high, so reset to ones to avoid a false edge after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_slv_cond.sv
module i2c_slv_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic bus_start,
  output logic bus_stop,
  output logic scl_rise
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // SDA moving while SCL stays high marks a bus condition
  assign bus_start = scl_s & scl_d &  sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d &  sda_s;
  assign scl_rise  = scl_s & ~scl_d;
endmodule

// File: rtl/i2c_slv_addr.sv
module i2c_slv_addr
  import i2c_slv_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_start,
  input  logic                   bus_stop,
  input  logic                   scl_rise,
  input  logic                   sda_s,
  input  logic [N_ID*ADDR_W-1:0] id_tbl,
  input  logic [ADDR_W-1:0]      alt_id,
  output logic                   match_ev,
  output logic                   match_rep,
  output logic [IDX_W-1:0]       match_idx,
  output logic                   gc_ev,
  output logic                   gc2_ev,
  output gc_kind_e               gc2_kind
);
  phase_e            ph;
  logic [3:0]        bitcnt;
  logic [ADDR_W-1:0] shreg;
  logic              rep_q;
  logic              gc_next;
  logic [7:0]        byte_w;
  logic [N_ID-1:0]   hits;
  logic [IDX_W-1:0]  hit_idx;
  logic              any_hit;

  assign byte_w = {shreg, sda_s};

  generate
    for (genvar i = 0; i < N_ID; i++) begin : g_cmp
      assign hits[i] = (byte_w[7:1] == id_tbl[i*ADDR_W +: ADDR_W]);
    end
  endgenerate

  // lowest index has priority
  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = N_ID - 1; i >= 0; i--) begin
      if (hits[i]) begin
        hit_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  function automatic gc_kind_e classify(input logic [7:0] b, input logic [ADDR_W-1:0] alt);
    if (b == GC_CODE_RST)                   return GC_RST_PROG;
    else if (b == GC_CODE_PROG)             return GC_PROG;
    else if (b[0] && (b[7:1] == alt))       return GC_ALT;
    else                                    return GC_NONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      rep_q     <= 1'b0;
      gc_next   <= 1'b0;
      match_ev  <= 1'b0;
      match_rep <= 1'b0;
      match_idx <= '0;
      gc_ev     <= 1'b0;
      gc2_ev    <= 1'b0;
      gc2_kind  <= GC_NONE;
    end else begin
      match_ev <= 1'b0;
      gc_ev    <= 1'b0;
      gc2_ev   <= 1'b0;
      if (bus_stop) begin
        ph     <= PH_IDLE;
        bitcnt <= '0;
      end else if (bus_start) begin
        rep_q   <= (ph != PH_IDLE);
        ph      <= PH_ADDR;
        bitcnt  <= '0;
        gc_next <= 1'b0;
      end else if (scl_rise && (ph == PH_ADDR || ph == PH_GC2)) begin
        if (bitcnt == 4'd8) begin
          // acknowledge clock ends the byte
          bitcnt <= '0;
          ph     <= (ph == PH_ADDR && gc_next) ? PH_GC2 : PH_XFER;
        end else begin
          bitcnt <= bitcnt + 4'd1;
          shreg  <= {shreg[ADDR_W-2:0], sda_s};
        end
        if (bitcnt == 4'd7) begin
          if (ph == PH_ADDR) begin
            if (byte_w == 8'h00) begin
              gc_next <= 1'b1;
              gc_ev   <= 1'b1;
            end else if (any_hit) begin
              match_ev  <= 1'b1;
              match_rep <= rep_q;
              match_idx <= hit_idx;
            end
          end else begin
            gc2_ev   <= 1'b1;
            gc2_kind <= classify(byte_w, alt_id);
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_slv_stat.sv
module i2c_slv_stat
  import i2c_slv_pkg::*;
#(
  parameter int TX_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_ev,
  input  logic              match_rep,
  input  logic [IDX_W-1:0]  match_idx,
  input  logic              gc_ev,
  input  logic              gc2_ev,
  input  gc_kind_e          gc2_kind,
  input  logic              bus_stop,
  input  logic              rx_byte,
  input  logic              rx_ovf,
  input  logic              rx_flush,
  input  logic              rd_empty,
  input  logic              tx_done,
  input  logic              tx_unf,
  input  logic              tx_pop,
  input  logic [1:0]        reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              cfg_gc_clr,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic [STAT_W-1:0] stat
);
  localparam int CW = $clog2(TX_DEPTH + 1);

  logic start_q, rstart_q, stopirq_q, gcirq_q, busy_q, pend_q;
  logic noack_q, ovf_q, rxirq_q, txirq_q, unf_q;
  logic [IDX_W-1:0] id_q;
  gc_kind_e gcid_q;
  logic [CW-1:0] tx_cnt;
  logic rd_stat, wr_stat, wr_tx, rd_rx, wr_cfg_clr, gc_rst, txnf;

  assign rd_stat    = reg_rd && (reg_sel == SEL_STAT);
  assign wr_stat    = reg_wr && (reg_sel == SEL_STAT);
  assign rd_rx      = reg_rd && (reg_sel == SEL_RX);
  assign wr_tx      = reg_wr && (reg_sel == SEL_TX);
  assign wr_cfg_clr = reg_wr && (reg_sel == SEL_CFG) && cfg_gc_clr;
  assign gc_rst     = gc2_ev && (gc2_kind == GC_RST_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {start_q, rstart_q, stopirq_q, gcirq_q, busy_q, pend_q} <= '0;
      {noack_q, ovf_q, rxirq_q, txirq_q, unf_q} <= '0;
      id_q   <= '0;
      gcid_q <= GC_NONE;
      tx_cnt <= '0;
    end else if (gc_rst) begin
      // reset call: back to defaults, keep the record of the call
      {start_q, rstart_q, stopirq_q, busy_q, pend_q} <= '0;
      {noack_q, ovf_q, rxirq_q, txirq_q, unf_q} <= '0;
      id_q    <= '0;
      tx_cnt  <= '0;
      gcirq_q <= 1'b1;
      gcid_q  <= GC_RST_PROG;
    end else begin
      // each flag: set event first, so set wins over clear
      if (match_ev && !match_rep) start_q <= 1'b1;
      else if (bus_stop)          start_q <= 1'b0;

      if (match_ev && match_rep)      rstart_q <= 1'b1;
      else if (bus_stop || rd_stat)   rstart_q <= 1'b0;

      if (match_ev) begin
        id_q   <= match_idx;
        busy_q <= 1'b1;
        pend_q <= 1'b1;
      end else if (bus_stop) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
      end

      if (bus_stop && pend_q) stopirq_q <= 1'b1;
      else if (rd_stat)       stopirq_q <= 1'b0;

      if (gc_ev)           gcirq_q <= 1'b1;
      else if (wr_cfg_clr) gcirq_q <= 1'b0;

      if (gc2_ev) gcid_q <= gc2_kind;

      if (rd_empty)     noack_q <= 1'b1;
      else if (rd_stat) noack_q <= 1'b0;

      if (rx_ovf)       ovf_q <= 1'b1;
      else if (rd_stat) ovf_q <= 1'b0;

      if (rx_byte)                rxirq_q <= 1'b1;
      else if (rd_rx || rx_flush) rxirq_q <= 1'b0;

      if (tx_done)    txirq_q <= 1'b1;
      else if (wr_tx) txirq_q <= 1'b0;

      if (tx_unf)       unf_q <= 1'b1;
      else if (wr_stat) unf_q <= 1'b0;

      case ({wr_tx, tx_pop})
        2'b10: if (tx_cnt < CW'(TX_DEPTH)) tx_cnt <= tx_cnt + CW'(1);
        2'b01: if (tx_cnt != '0)           tx_cnt <= tx_cnt - CW'(1);
        default: ;
      endcase
    end
  end

  assign txnf = (tx_cnt < CW'(TX_DEPTH));

  assign stat = {start_q, rstart_q, id_q, stopirq_q, gcid_q, gcirq_q,
                 busy_q, noack_q, ovf_q, rxirq_q, txirq_q, unf_q, txnf};

  assign reg_rdata = (reg_sel == SEL_STAT) ? {{(BUS_W-STAT_W){1'b0}}, stat} : '0;
endmodule

// File: rtl/i2c_slv_status.sv
module i2c_slv_status
  import i2c_slv_pkg::*;
#(
  parameter int TX_DEPTH    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [N_ID*ADDR_W-1:0] id_tbl_i,
  input  logic [ADDR_W-1:0]      alt_id_i,
  input  logic                   rx_byte_i,
  input  logic                   rx_ovf_i,
  input  logic                   rx_flush_i,
  input  logic                   rd_empty_i,
  input  logic                   tx_done_i,
  input  logic                   tx_unf_i,
  input  logic                   tx_pop_i,
  input  logic [1:0]             reg_sel_i,
  input  logic                   reg_rd_i,
  input  logic                   reg_wr_i,
  input  logic [BUS_W-1:0]       reg_wdata_i,
  output logic [BUS_W-1:0]       reg_rdata_o,
  output logic [STAT_W-1:0]      stat_o
);
  logic scl_s, sda_s;
  logic det_start, det_stop, det_rise;
  logic match_ev, match_rep, gc_ev, gc2_ev;
  logic [IDX_W-1:0] match_idx;
  gc_kind_e gc2_kind;
  logic unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[BUS_W-1:CFG_GC_CLR_BIT+1], reg_wdata_i[CFG_GC_CLR_BIT-1:0]};

  i2c_slv_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .d   ({scl_i, sda_i}),
    .q   ({scl_s, sda_s})
  );

  i2c_slv_cond u_cond (
    .clk (clk), .rst_n (rst_n),
    .scl_s (scl_s), .sda_s (sda_s),
    .bus_start (det_start), .bus_stop (det_stop), .scl_rise (det_rise)
  );

  i2c_slv_addr u_addr (
    .clk (clk), .rst_n (rst_n),
    .bus_start (det_start), .bus_stop (det_stop), .scl_rise (det_rise), .sda_s (sda_s),
    .id_tbl (id_tbl_i), .alt_id (alt_id_i),
    .match_ev (match_ev), .match_rep (match_rep), .match_idx (match_idx),
    .gc_ev (gc_ev), .gc2_ev (gc2_ev), .gc2_kind (gc2_kind)
  );

  i2c_slv_stat #(.TX_DEPTH(TX_DEPTH)) u_stat (
    .clk (clk), .rst_n (rst_n),
    .match_ev (match_ev), .match_rep (match_rep), .match_idx (match_idx),
    .gc_ev (gc_ev), .gc2_ev (gc2_ev), .gc2_kind (gc2_kind),
    .bus_stop (det_stop),
    .rx_byte (rx_byte_i), .rx_ovf (rx_ovf_i), .rx_flush (rx_flush_i),
    .rd_empty (rd_empty_i), .tx_done (tx_done_i), .tx_unf (tx_unf_i), .tx_pop (tx_pop_i),
    .reg_sel (reg_sel_i), .reg_rd (reg_rd_i), .reg_wr (reg_wr_i),
    .cfg_gc_clr (reg_wdata_i[CFG_GC_CLR_BIT]),
    .reg_rdata (reg_rdata_o), .stat (stat_o)
  );
endmodule

// File: rtl/i2c_slv_status_chk.sv
module i2c_slv_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  reg_sel,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic        cfg_bit,
  input logic [31:0] reg_rdata,
  input logic [14:0] stat,
  input logic        ev_nodata,
  input logic        ev_rx_byte,
  input logic        ev_rx_flush,
  input logic        ev_tx_done,
  input logic        bus_stop,
  input logic        gc_first,
  input logic        gc_second
);
  logic unused_stat;
  assign unused_stat = ^{stat[12:10], stat[4], stat[1]};

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:15] == 17'd0);

  assert_busy_with_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[6]) |-> (stat[14] || stat[13]));

  assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[14]) |-> ($past(bus_stop) || stat[9:8] == 2'b01));

  assert_gcirq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3 && cfg_bit && !gc_first && !gc_second) |=> !stat[7]);

  assert_noack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == 2'd0 && !ev_nodata) |=> !stat[5]);

  assert_rxirq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (((reg_rd && reg_sel == 2'd1) || ev_rx_flush) && !ev_rx_byte) |=> !stat[3]);

  assert_txirq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2 && !ev_tx_done) |=> !stat[2]);

  assert_txnf_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[0]) |-> $past(reg_wr && reg_sel == 2'd2));

  assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nodata && !gc_second) |=> stat[5]);
endmodule

bind i2c_slv_status i2c_slv_status_chk u_chk (
  .clk (clk), .rst_n (rst_n),
  .reg_sel (reg_sel_i), .reg_rd (reg_rd_i), .reg_wr (reg_wr_i),
  .cfg_bit (reg_wdata_i[8]), .reg_rdata (reg_rdata_o), .stat (stat_o),
  .ev_nodata (rd_empty_i), .ev_rx_byte (rx_byte_i), .ev_rx_flush (rx_flush_i),
  .ev_tx_done (tx_done_i), .bus_stop (det_stop),
  .gc_first (gc_ev), .gc_second (gc2_ev)
);

// File: tb/i2c_slv_status_tb.sv
module i2c_slv_status_tb;
  localparam int H = 8;
  localparam logic [6:0] ID0 = 7'h21, ID1 = 7'h35, ID2 = 7'h50, ID3 = 7'h50, ALT = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl = 1'b1, sda = 1'b1;
  logic rx_byte = 0, rx_ovf = 0, rx_flush = 0, rd_empty = 0, tx_done = 0, tx_unf = 0, tx_pop = 0;
  logic [1:0] sel = 2'd0;
  logic rd = 0, wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [14:0] stat;

  i2c_slv_status u_dut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda),
    .id_tbl_i ({ID3, ID2, ID1, ID0}), .alt_id_i (ALT),
    .rx_byte_i (rx_byte), .rx_ovf_i (rx_ovf), .rx_flush_i (rx_flush),
    .rd_empty_i (rd_empty), .tx_done_i (tx_done), .tx_unf_i (tx_unf), .tx_pop_i (tx_pop),
    .reg_sel_i (sel), .reg_rd_i (rd), .reg_wr_i (wr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .stat_o (stat)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [14:0] exp_s = 15'h0001;
  bit pend = 0, open_t = 0;
  int txc = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic chk_stat(input string tag);
    chk(tag, {17'd0, stat}, {17'd0, exp_s});
  endtask

  function automatic int find_id(input logic [6:0] a);
    if (a == ID0) return 0;
    if (a == ID1) return 1;
    if (a == ID2) return 2;
    if (a == ID3) return 3;
    return -1;
  endfunction

  function automatic logic [1:0] gc_kind(input logic [7:0] b);
    if (b == 8'h06) return 2'b01;
    if (b == 8'h04) return 2'b10;
    if (b[0] && b[7:1] == ALT) return 2'b11;
    return 2'b00;
  endfunction

  // ---------------- I2C line driving ----------------
  task automatic i2c_start();      // also a repeated START when SCL is low
    sda = 1'b1; tick(H);
    scl = 1'b1; tick(H);
    sda = 1'b0; tick(H);
    scl = 1'b0; tick(H);
  endtask

  task automatic i2c_stop();
    sda = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    sda = 1'b1; tick(H);
    if (pend) exp_s[10] = 1'b1;
    exp_s[14] = 1'b0; exp_s[13] = 1'b0; exp_s[6] = 1'b0;
    pend = 0; open_t = 0;
  endtask

  task automatic send_bit(input logic b);
    sda = b;    tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    send_bit(1'b1);                 // acknowledge slot, line released
  endtask

  task automatic do_addr(input logic [7:0] b);
    int k;
    bit was_open;
    was_open = open_t;
    k = find_id(b[7:1]);
    i2c_start();
    open_t = 1;
    send_byte(b);
    if (b == 8'h00) exp_s[7] = 1'b1;
    else if (k >= 0) begin
      if (was_open) exp_s[13] = 1'b1; else exp_s[14] = 1'b1;
      exp_s[12:11] = 2'(k);
      exp_s[6] = 1'b1;
      pend = 1;
    end
  endtask

  task automatic do_gc2(input logic [7:0] b);
    logic [1:0] k;
    k = gc_kind(b);
    send_byte(b);
    if (k == 2'b01) begin
      exp_s = 15'h0181;
      pend = 0; txc = 0;
    end else exp_s[9:8] = k;
  endtask

  // ---------------- register port ----------------
  task automatic read_reg(input logic [1:0] s, input string tag);
    sel = s; rd = 1'b1;
    #1;
    chk(tag, rdata, (s == 2'd0) ? {17'd0, exp_s} : 32'd0);
    @(negedge clk);
    rd = 1'b0;
    if (s == 2'd0) begin
      exp_s[13] = 1'b0; exp_s[10] = 1'b0; exp_s[5] = 1'b0; exp_s[4] = 1'b0;
    end
    if (s == 2'd1) exp_s[3] = 1'b0;
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [31:0] d);
    sel = s; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    case (s)
      2'd0: exp_s[1] = 1'b0;
      2'd2: begin
        exp_s[2] = 1'b0;
        if (txc < 2) txc++;
        exp_s[0] = (txc < 2);
      end
      2'd3: if (d[8]) exp_s[7] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic pulse(input int w);
    case (w)
      0: rd_empty = 1'b1;
      1: rx_ovf   = 1'b1;
      2: rx_byte  = 1'b1;
      3: rx_flush = 1'b1;
      4: tx_done  = 1'b1;
      5: tx_unf   = 1'b1;
      default: tx_pop = 1'b1;
    endcase
    @(negedge clk);
    {rd_empty, rx_ovf, rx_byte, rx_flush, tx_done, tx_unf, tx_pop} = '0;
    case (w)
      0: exp_s[5] = 1'b1;
      1: exp_s[4] = 1'b1;
      2: exp_s[3] = 1'b1;
      3: exp_s[3] = 1'b0;
      4: exp_s[2] = 1'b1;
      5: exp_s[1] = 1'b1;
      default: begin
        if (txc > 0) txc--;
        exp_s[0] = (txc < 2);
      end
    endcase
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [6:0] a7;
    logic [7:0] ab;
    void'($urandom(32'h5A17_C3E1));
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1: reset value and read map
    chk_stat("R1 reset status");
    read_reg(2'd0, "R1 status read");
    read_reg(2'd2, "R1 TX reads zero");
    read_reg(2'd3, "R1 config reads zero");

    // R2, R4, R5: plain START with ID1
    do_addr({ID1, 1'b0});
    chk_stat("R2 start flag, busy and R4 index 1");
    i2c_stop();
    chk_stat("R2 cleared by STOP, R5 stop flag set");
    read_reg(2'd0, "R5 status read");
    chk_stat("R5 stop flag cleared by read");

    // R4: duplicate identifiers, lowest index wins; non-matching ignored
    do_addr({ID3, 1'b1});
    chk_stat("R4 duplicate IDs give index 2");
    i2c_stop();
    read_reg(2'd0, "R5 read after dup");
    do_addr(8'hFE);
    chk_stat("R4 no-match leaves status");
    i2c_stop();
    chk_stat("R5 STOP without match sets nothing");

    // R3: repeated START after a non-matching address
    do_addr(8'hFE);
    do_addr({ID0, 1'b0});
    chk_stat("R3 repeated-start flag, start flag clear");
    read_reg(2'd0, "R3 status read");
    chk_stat("R3 cleared by status read");
    i2c_stop();
    read_reg(2'd0, "R5 read after rep");

    // R2/R3: start flag survives a status read, dies at STOP
    do_addr({ID0, 1'b0});
    do_addr({ID1, 1'b0});
    chk_stat("R3 both flags, R4 index follows last match");
    read_reg(2'd0, "R2 read during transfer");
    chk_stat("R2 start flag kept across status read");
    i2c_stop();
    chk_stat("R2 start flag cleared by STOP");
    read_reg(2'd0, "R5 clear");

    // R6, R8: general call, program only
    do_addr(8'h00);
    chk_stat("R6 general-call interrupt");
    do_gc2(8'h04);
    chk_stat("R6 program-only code 10");
    i2c_stop();
    write_reg(2'd3, 32'h0000_00FF);
    chk_stat("R8 config write without bit 8 keeps flag");
    write_reg(2'd3, 32'h0000_0100);
    chk_stat("R8 config bit 8 clears flag");

    // R6: alternative-ID and unknown second bytes
    do_addr(8'h00);
    do_gc2({ALT, 1'b1});
    chk_stat("R6 alternative-ID code 11");
    i2c_stop();
    do_addr(8'h00);
    do_gc2(8'h08);
    chk_stat("R6 unknown code gives 00");
    i2c_stop();
    write_reg(2'd3, 32'h0000_0100);

    // R7: general-call reset wipes state
    pulse(0); pulse(2); pulse(5);
    write_reg(2'd2, 32'h0);
    do_addr({ID0, 1'b0});
    chk_stat("R7 preloaded state");
    do_addr(8'h00);
    do_gc2(8'h06);
    chk_stat("R7 reset call gives 0x0181");
    i2c_stop();
    chk_stat("R7 no stop flag after reset call");
    write_reg(2'd3, 32'h0000_0100);

    // R9, R10, R11
    pulse(0); pulse(1);
    chk_stat("R9 no-data and overflow set");
    read_reg(2'd0, "R9 status read");
    chk_stat("R9 cleared by read");
    pulse(2);
    read_reg(2'd1, "R10 RX read returns zero");
    chk_stat("R10 RX read clears");
    pulse(2); pulse(3);
    chk_stat("R10 flush clears");
    pulse(4); pulse(5);
    chk_stat("R11 tx-done and underflow set");
    write_reg(2'd0, 32'h0);
    chk_stat("R11 status write clears underflow");
    write_reg(2'd2, 32'h0);
    chk_stat("R11 TX write clears tx-done");

    // R12: occupancy with saturation
    write_reg(2'd2, 32'h0);
    chk_stat("R12 two writes clear not-full");
    write_reg(2'd2, 32'h0);
    pulse(6);
    chk_stat("R12 pop sets not-full after saturation");
    pulse(6); pulse(6);
    write_reg(2'd2, 32'h0);
    chk_stat("R12 pop saturates at zero");
    pulse(6);

    // R13: set and clear in the same cycle
    sel = 2'd0; rd = 1'b1; rd_empty = 1'b1;
    @(negedge clk);
    rd = 1'b0; rd_empty = 1'b0;
    exp_s[13] = 1'b0; exp_s[10] = 1'b0; exp_s[4] = 1'b0;
    exp_s[5] = 1'b1;
    chk_stat("R13 set beats status-read clear");
    read_reg(2'd0, "R13 clear afterwards");

    // random mix against the bench model
    for (int it = 0; it < 40; it++) begin
      case ($urandom_range(0, 7))
        0: begin
          a7 = ($urandom_range(0, 1) == 1) ? find_idv($urandom_range(0, 3)) : 7'($urandom);
          if (a7 == 7'h00) a7 = 7'h11;
          ab = {a7, 1'($urandom)};
          do_addr(ab);
          chk_stat("R2/R4 random address");
          if ($urandom_range(0, 1) == 1) send_byte(8'($urandom));
          i2c_stop();
          chk_stat("R5 random STOP");
        end
        1: begin pulse($urandom_range(0, 6)); chk_stat("R9/R10/R11/R12 random strobe"); end
        2: begin read_reg(2'd0, "R1 random status read"); chk_stat("R9 after random read"); end
        3: begin write_reg(2'd2, 32'($urandom)); chk_stat("R12 random TX write"); end
        4: begin read_reg(2'd1, "R10 random RX read"); chk_stat("R10 after random RX read"); end
        5: begin write_reg(2'd3, 32'($urandom)); chk_stat("R8 random config write"); end
        6: begin write_reg(2'd0, 32'($urandom)); chk_stat("R11 random status write"); end
        default: begin pulse(6); chk_stat("R12 random pop"); end
      endcase
    end

    done = 1;
    finish_run();
  end

  function automatic logic [6:0] find_idv(input int i);
    case (i)
      0: return ID0;
      1: return ID1;
      2: return ID2;
      default: return ID3;
    endcase
  endfunction
endmodule